// File: doc/BRIEF.md
# Direct-Mapped Write-Through Data Cache

This block sits between a processor load/store port and a slower memory. It holds 64 lines of 16 bytes. Each line has a valid bit and a stored tag, and a lookup hits when the valid bit is set and the stored tag equals the address tag. A 32-bit byte address is split into three fields. Bits [3:0] are the offset inside the line. Bits [9:4] are the line index, which is the block address modulo 64. Bits [31:10] are the tag. For example, byte address 1200 is block 75, so it maps to index 11.

Every store goes through to memory by way of a 4-entry posted-write FIFO of address/data pairs. The FIFO drains in order over a valid/ready handshake. A store completes in the same cycle unless the FIFO is full. On a store hit the cached word is also updated. On a store miss no line is allocated: only the memory write is queued.

A load hit returns its word in the same cycle. A load miss stalls the requester. The controller first waits until the FIFO is empty, then requests the line, collects four word beats, and marks the line valid with its tag. The request, which is still held, then hits.

The controller has four states:
- IDLE serves hits and stores.
- DRAIN waits for the write FIFO to empty.
- FETCH presents the line request.
- FILL collects the beats.

Its transitions are:
- IDLE to DRAIN on a load miss while the FIFO holds entries.
- IDLE to FETCH on a load miss while the FIFO is empty.
- DRAIN to FETCH once the FIFO is empty.
- FETCH to FILL when the request is accepted.
- FILL to IDLE on the last beat.

Top module: `wtc_cache`

## Requirements
- R1: The tag is address bits [31:10], the index is bits [9:4], and bits [3:2] select one of four 32-bit words in the line. Bits [1:0] have no effect on any lookup or on any queued memory address.
- R2: After reset every line is invalid, so the first load to any line misses and issues a line request. The bus request outputs (mr_valid, mw_valid) are low after reset.
- R3: A load that hits (valid set and tag equal) raises cpu_ready in the same cycle with the stored word on cpu_rdata, and it issues no memory request.
- R4: A load miss holds cpu_ready low. It issues one line request with a line-aligned address (bits [3:0] zero), held stable until accepted. It takes four beats in word order 0 to 3 and then returns the requested word.
- R5: Every accepted store is queued and written to memory in issue order. A store hit also updates the cached word, so a later load hit returns the new data.
- R6: A store miss does not allocate a line: the line held at that index stays resident, and a later load to the stored address misses.
- R7: A store raises cpu_ready in the same cycle unless the write FIFO already holds 4 entries, in which case cpu_ready stays low until an entry drains.
- R8: A load miss issues no line request while any queued write is still pending, so the fetched line reflects all earlier stores.
- R9: Two addresses with equal index and different tags evict each other; for example byte addresses 1200 and 176 both use index 11.
- R10: While mw_ready is low, mw_valid, mw_addr and mw_data stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data |
| cpu_ready | output | 1 | Access completes this cycle |
| cpu_rdata | output | 32 | Load data, valid with cpu_ready on a load |
| mr_valid | output | 1 | Line read request |
| mr_ready | input | 1 | Memory accepts the line request |
| mr_addr | output | 32 | Line-aligned read address |
| mr_rvalid | input | 1 | Read beat valid |
| mr_rdata | input | 32 | Read beat data |
| mw_valid | output | 1 | Queued write available |
| mw_ready | input | 1 | Memory accepts the write |
| mw_addr | output | 32 | Word-aligned write address |
| mw_data | output | 32 | Write data |

## Verification
The bench first sweeps every index with loads to all four words. The first load of each line must miss with the right line address, and the other three loads must hit with no bus traffic, which separates index and word decoding from tag matching. Loads with nonzero low address bits and pairs of addresses with the same index and different tags separate field slicing from eviction. Store hits and store misses are then issued against resident lines, which tells update-in-place apart from write-around. With memory writes blocked, a burst of stores shows where the FIFO becomes full and in what order the writes drain. A blocked store followed by a load miss to the same address shows whether the fetch waits for the drain.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DRAIN = 2'd1,
        ST_FETCH = 2'd2,
        ST_FILL  = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/wtc_wbuf.sv
// Posted-write FIFO of address/data pairs; DEPTH must be a power of two.
module wtc_wbuf #(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic          full,
    output logic          empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    logic [AW-1:0] addr_q [DEPTH];
    logic [DW-1:0] data_q [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    always_ff @(posedge clk) begin
        if (push) begin
            addr_q[wr_ptr] <= push_addr;
            data_q[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + 1'b1;
            if (pop)  rd_ptr <= rd_ptr + 1'b1;
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head_addr = addr_q[rd_ptr];
    assign head_data = data_q[rd_ptr];
    assign full      = (count == CW'(DEPTH));
    assign empty     = (count == '0);
endmodule

// File: rtl/wtc_store.sv
// Valid bits, tag array and word array with combinational lookup.
module wtc_store #(
    parameter int TAG_W   = 22,
    parameter int INDEX_W = 6,
    parameter int WSEL_W  = 2,
    parameter int DW      = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TAG_W-1:0]   lk_tag,
    input  logic [INDEX_W-1:0] lk_index,
    input  logic [WSEL_W-1:0]  lk_word,
    input  logic               wr_en,
    input  logic [DW-1:0]      wr_data,
    input  logic               fill_en,
    input  logic [WSEL_W-1:0]  fill_word,
    input  logic [DW-1:0]      fill_data,
    input  logic               fill_last,
    output logic               hit,
    output logic [DW-1:0]      rd_data
);
    localparam int LINES   = 1 << INDEX_W;
    localparam int WORDS   = 1 << WSEL_W;
    localparam int ENTRIES = LINES * WORDS;

    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q  [LINES];
    logic [DW-1:0]    word_q [ENTRIES];

    logic [INDEX_W+WSEL_W-1:0] rd_slot, fill_slot;
    assign rd_slot   = {lk_index, lk_word};
    assign fill_slot = {lk_index, fill_word};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         valid_q <= '0;
        else if (fill_last) valid_q[lk_index] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (fill_last) tag_q[lk_index] <= lk_tag;
        if (fill_en)   word_q[fill_slot] <= fill_data;
        else if (wr_en) word_q[rd_slot] <= wr_data;
    end

    assign hit     = valid_q[lk_index] && (tag_q[lk_index] == lk_tag);
    assign rd_data = word_q[rd_slot];
endmodule

// File: rtl/wtc_ctrl.sv
// Access sequencer: serves hits/stores, drains, fetches and fills lines.
module wtc_ctrl
    import wtc_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int WSEL_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic              hit,
    input  logic              wb_full,
    input  logic              wb_empty,
    input  logic              mr_ready,
    input  logic              mr_rvalid,
    output logic              cpu_ready,
    output logic              wb_push,
    output logic              line_wr,
    output logic              mr_valid,
    output logic              fill_en,
    output logic [WSEL_W-1:0] fill_word,
    output logic              fill_last,
    output ctl_state_t        state_o
);
    ctl_state_t        state_q, state_d;
    logic [WSEL_W-1:0] beat_q;
    logic              last_beat;

    assign last_beat = (beat_q == WSEL_W'(WORDS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            beat_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_FETCH)                   beat_q <= '0;
            else if (state_q == ST_FILL && mr_rvalid)  beat_q <= beat_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req && !we && !hit) state_d = wb_empty ? ST_FETCH : ST_DRAIN;
            ST_DRAIN: if (wb_empty)           state_d = ST_FETCH;
            ST_FETCH: if (mr_ready)           state_d = ST_FILL;
            ST_FILL:  if (mr_rvalid && last_beat) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        cpu_ready = 1'b0;
        wb_push   = 1'b0;
        line_wr   = 1'b0;
        mr_valid  = 1'b0;
        fill_en   = 1'b0;
        fill_last = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wb_push   = req && we && !wb_full;
                line_wr   = req && we && !wb_full && hit;
                cpu_ready = req && (we ? !wb_full : hit);
            end
            ST_DRAIN: ;
            ST_FETCH: mr_valid = 1'b1;
            ST_FILL: begin
                fill_en   = mr_rvalid;
                fill_last = mr_rvalid && last_beat;
            end
            default: ;
        endcase
    end

    assign fill_word = beat_q;
    assign state_o   = state_q;
endmodule

// File: rtl/wtc_cache.sv
module wtc_cache
    import wtc_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int INDEX_W    = 6,
    parameter int OFFSET_W   = 4,
    parameter int WBUF_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mr_valid,
    input  logic              mr_ready,
    output logic [ADDR_W-1:0] mr_addr,
    input  logic              mr_rvalid,
    input  logic [DATA_W-1:0] mr_rdata,
    output logic              mw_valid,
    input  logic              mw_ready,
    output logic [ADDR_W-1:0] mw_addr,
    output logic [DATA_W-1:0] mw_data
);
    localparam int TAG_W  = ADDR_W - INDEX_W - OFFSET_W;
    localparam int WSEL_W = OFFSET_W - 2;
    localparam int WORDS  = 1 << WSEL_W;

    logic              hit, wb_push, wb_full, wb_empty, wb_pop, line_wr;
    logic              fill_en, fill_last;
    logic [WSEL_W-1:0] fill_word;
    logic [DATA_W-1:0] line_word;
    ctl_state_t        state;
    logic              unused_lsb;

    assign unused_lsb = ^cpu_addr[1:0];

    wtc_ctrl #(.WORDS(WORDS), .WSEL_W(WSEL_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .req(cpu_req), .we(cpu_we), .hit(hit),
        .wb_full(wb_full), .wb_empty(wb_empty),
        .mr_ready(mr_ready), .mr_rvalid(mr_rvalid),
        .cpu_ready(cpu_ready), .wb_push(wb_push), .line_wr(line_wr),
        .mr_valid(mr_valid), .fill_en(fill_en), .fill_word(fill_word),
        .fill_last(fill_last), .state_o(state)
    );

    wtc_store #(.TAG_W(TAG_W), .INDEX_W(INDEX_W), .WSEL_W(WSEL_W), .DW(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .lk_tag(cpu_addr[ADDR_W-1 -: TAG_W]),
        .lk_index(cpu_addr[OFFSET_W +: INDEX_W]),
        .lk_word(cpu_addr[2 +: WSEL_W]),
        .wr_en(line_wr), .wr_data(cpu_wdata),
        .fill_en(fill_en), .fill_word(fill_word), .fill_data(mr_rdata),
        .fill_last(fill_last),
        .hit(hit), .rd_data(line_word)
    );

    assign wb_pop = mw_valid && mw_ready;

    wtc_wbuf #(.AW(ADDR_W), .DW(DATA_W), .DEPTH(WBUF_DEPTH)) u_wbuf (
        .clk(clk), .rst_n(rst_n),
        .push(wb_push), .push_addr({cpu_addr[ADDR_W-1:2], 2'b00}), .push_data(cpu_wdata),
        .pop(wb_pop), .head_addr(mw_addr), .head_data(mw_data),
        .full(wb_full), .empty(wb_empty)
    );

    assign mw_valid  = !wb_empty;
    assign mr_addr   = {cpu_addr[ADDR_W-1:OFFSET_W], {OFFSET_W{1'b0}}};
    assign cpu_rdata = line_word;
endmodule

// File: rtl/wtc_chk.sv
module wtc_chk
    import wtc_pkg::*;
#(
    parameter int AW       = 32,
    parameter int DW       = 32,
    parameter int OFFSET_W = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_req,
    input logic          cpu_we,
    input logic          cpu_ready,
    input logic          mr_valid,
    input logic          mr_ready,
    input logic [AW-1:0] mr_addr,
    input logic          mw_valid,
    input logic          mw_ready,
    input logic [AW-1:0] mw_addr,
    input logic [DW-1:0] mw_data,
    input logic          wb_full,
    input ctl_state_t    state
);
    p_fetch_after_drain_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mr_valid |-> !mw_valid);

    p_fetch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mr_valid && !mr_ready |=> mr_valid && $stable(mr_addr));

    p_line_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mr_valid |-> (mr_addr[OFFSET_W-1:0] == '0));

    p_no_ready_in_fetch_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE) |-> !cpu_ready);

    p_store_stall_full_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req && cpu_we && wb_full |-> !cpu_ready);

    p_wbuf_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid && !mw_ready |=> mw_valid && $stable(mw_addr) && $stable(mw_data));

    p_word_align_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mw_valid |-> (mw_addr[1:0] == 2'b00));
endmodule

bind wtc_cache wtc_chk #(.AW(ADDR_W), .DW(DATA_W), .OFFSET_W(OFFSET_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
    .cpu_ready(cpu_ready), .mr_valid(mr_valid), .mr_ready(mr_ready),
    .mr_addr(mr_addr), .mw_valid(mw_valid), .mw_ready(mw_ready),
    .mw_addr(mw_addr), .mw_data(mw_data), .wb_full(wb_full), .state(state)
);

// File: tb/wtc_cache_tb.sv
`timescale 1ns/1ps
module wtc_cache_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ready;
    logic [31:0] cpu_rdata;
    logic        mr_valid, mr_rvalid = 1'b0;
    logic        mr_ready = 1'b1;
    logic [31:0] mr_addr, mr_rdata = '0;
    logic        mw_valid, mw_ready = 1'b1;
    logic [31:0] mw_addr, mw_data;

    always #2 clk = ~clk;

    wtc_cache u_dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
        .cpu_rdata(cpu_rdata), .mr_valid(mr_valid), .mr_ready(mr_ready),
        .mr_addr(mr_addr), .mr_rvalid(mr_rvalid), .mr_rdata(mr_rdata),
        .mw_valid(mw_valid), .mw_ready(mw_ready), .mw_addr(mw_addr), .mw_data(mw_data)
    );

    // Memory model: 4 KiB, addresses above bit 11 kept zero.
    logic [31:0] mem    [1024];
    logic [31:0] shadow [1024];
    logic [31:0] wlog   [64];
    int          wlog_n = 0;
    int          rd_reqs = 0;
    logic [31:0] last_mr_addr = '0;
    logic [31:0] rsp_base = '0;
    logic [1:0]  rsp_beat = '0;
    int          rsp_wait = 0;
    logic        rsp_act = 1'b0;

    function automatic logic [31:0] init_word(int i);
        return 32'hC0DE_0000 | 32'(i * 7);
    endfunction

    initial begin
        for (int i = 0; i < 1024; i++) begin
            mem[i]    = init_word(i);
            shadow[i] = init_word(i);
        end
    end

    always @(posedge clk) begin
        mr_rvalid <= 1'b0;
        if (mr_valid && mr_ready) begin
            rsp_base     <= mr_addr;
            last_mr_addr <= mr_addr;
            rd_reqs      <= rd_reqs + 1;
            rsp_wait     <= 2;
            rsp_beat     <= 2'd0;
            rsp_act      <= 1'b1;
        end else if (rsp_act) begin
            if (rsp_wait > 0) rsp_wait <= rsp_wait - 1;
            else begin
                mr_rvalid <= 1'b1;
                mr_rdata  <= mem[{rsp_base[11:4], rsp_beat}];
                rsp_beat  <= rsp_beat + 2'd1;
                if (rsp_beat == 2'd3) rsp_act <= 1'b0;
            end
        end
        if (mw_valid && mw_ready) begin
            mem[mw_addr[11:2]] <= mw_data;
            wlog[wlog_n % 64]  <= mw_addr;
            wlog_n             <= wlog_n + 1;
        end
    end

    int  n_checks = 0, n_fail = 0;
    bit  reported = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        end
    endtask

    task automatic access(input logic we, input logic [31:0] a, input logic [31:0] d,
                          output logic [31:0] rd, output int cyc);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        #1;
        while (!cpu_ready) begin
            @(negedge clk); #1;
            cyc++;
        end
        rd = cpu_rdata;
        if (we) shadow[a[11:2]] = d;
        @(posedge clk); #1;
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        report();
        $finish;
    end

    initial begin
        logic [31:0] rd;
        int          cyc, r0, w0;
        logic [31:0] a;
        logic [31:0] seq [5];

        idle(5);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(mr_valid == 1'b0, "R2", "reset mr_valid", {31'b0, mr_valid}, 0);
        check(mw_valid == 1'b0, "R2", "reset mw_valid", {31'b0, mw_valid}, 0);
        check(cpu_ready == 1'b0, "R2", "reset cpu_ready", {31'b0, cpu_ready}, 0);

        // R2/R3/R4 sweep: every index, every word.
        for (int idx = 0; idx < 64; idx++) begin
            for (int w = 0; w < 4; w++) begin
                a  = 32'(idx * 16 + w * 4);
                r0 = rd_reqs;
                access(1'b0, a, '0, rd, cyc);
                if (w == 0) begin
                    check(cyc > 0, "R2", "first load stalls", 32'(cyc), 1);
                    check(rd_reqs == r0 + 1, "R4", "one line request", 32'(rd_reqs - r0), 1);
                    check(last_mr_addr == 32'(idx * 16), "R4", "line address", last_mr_addr, 32'(idx * 16));
                end else begin
                    check(cyc == 0, "R3", "hit same cycle", 32'(cyc), 0);
                    check(rd_reqs == r0, "R3", "no request on hit", 32'(rd_reqs - r0), 0);
                end
                check(rd == shadow[a[11:2]], "R4", "load data", rd, shadow[a[11:2]]);
            end
        end

        // R1 slicing: 1200 is block 75, index 11, tag 1; low bits ignored.
        r0 = rd_reqs;
        access(1'b0, 32'd1203, '0, rd, cyc);
        check(rd_reqs == r0 + 1, "R1", "1203 misses (tag 1)", 32'(rd_reqs - r0), 1);
        check(last_mr_addr == 32'd1200, "R1", "line of 1203", last_mr_addr, 32'd1200);
        check(rd == shadow[300], "R1", "word of 1203", rd, shadow[300]);
        access(1'b0, 32'd1202, '0, rd, cyc);
        check(cyc == 0, "R1", "1202 hits same word", 32'(cyc), 0);
        check(rd == shadow[300], "R1", "1202 data", rd, shadow[300]);
        access(1'b0, 32'd1213, '0, rd, cyc);
        check(cyc == 0 && rd == shadow[303], "R1", "word 3 of line 75", rd, shadow[303]);

        // R9 conflict on index 11.
        r0 = rd_reqs;
        access(1'b0, 32'd176, '0, rd, cyc);
        check(rd_reqs == r0 + 1, "R9", "176 evicted by 1200", 32'(rd_reqs - r0), 1);
        check(rd == shadow[44], "R9", "176 data", rd, shadow[44]);
        r0 = rd_reqs;
        access(1'b0, 32'd1200, '0, rd, cyc);
        check(rd_reqs == r0 + 1, "R9", "1200 evicted by 176", 32'(rd_reqs - r0), 1);

        // R5 store hit.
        access(1'b1, 32'h20, 32'h1111_2222, rd, cyc);
        check(cyc == 0, "R7", "store with room", 32'(cyc), 0);
        access(1'b0, 32'h20, '0, rd, cyc);
        check(cyc == 0 && rd == 32'h1111_2222, "R5", "store hit updates line", rd, 32'h1111_2222);
        idle(4);
        check(mem[8] == 32'h1111_2222, "R5", "store reaches memory", mem[8], 32'h1111_2222);

        // R6 write-around.
        access(1'b1, 32'h840, 32'hABCD_0001, rd, cyc);
        idle(4);
        r0 = rd_reqs;
        access(1'b0, 32'h40, '0, rd, cyc);
        check(cyc == 0 && rd_reqs == r0, "R6", "resident line kept", 32'(cyc), 0);
        access(1'b0, 32'h840, '0, rd, cyc);
        check(rd_reqs == r0 + 1, "R6", "stored address still misses", 32'(rd_reqs - r0), 1);
        check(rd == 32'hABCD_0001, "R6", "fetched store data", rd, 32'hABCD_0001);

        // R7 full FIFO, R5 order.
        seq[0] = 32'h100; seq[1] = 32'h104; seq[2] = 32'h908; seq[3] = 32'h30C; seq[4] = 32'h110;
        @(negedge clk); mw_ready = 1'b0;
        w0 = wlog_n;
        for (int k = 0; k < 4; k++) begin
            access(1'b1, seq[k], 32'h5500_0000 | 32'(k), rd, cyc);
            check(cyc == 0, "R7", "store accepted below full", 32'(cyc), 0);
        end
        fork
            access(1'b1, seq[4], 32'h5500_0004, rd, cyc);
            begin idle(10); @(negedge clk); mw_ready = 1'b1; end
        join
        check(cyc >= 8, "R7", "store stalls on full FIFO", 32'(cyc), 8);
        idle(8);
        check(wlog_n == w0 + 5, "R5", "all stores drained", 32'(wlog_n - w0), 5);
        for (int k = 0; k < 5; k++)
            check(wlog[(w0 + k) % 64] == seq[k], "R5", "drain order", wlog[(w0 + k) % 64], seq[k]);
        access(1'b0, 32'h104, '0, rd, cyc);
        check(rd == 32'h5500_0001, "R5", "hit after store", rd, 32'h5500_0001);

        // R8 drain before fetch.
        @(negedge clk); mw_ready = 1'b0;
        access(1'b1, 32'hC50, 32'hFEED_0005, rd, cyc);
        r0 = rd_reqs;
        fork
            access(1'b0, 32'hC50, '0, rd, cyc);
            begin idle(6); @(negedge clk); mw_ready = 1'b1; end
        join
        check(cyc > 6, "R8", "load waits for drain", 32'(cyc), 7);
        check(rd == 32'hFEED_0005, "R8", "load sees queued store", rd, 32'hFEED_0005);
        check(rd_reqs == r0 + 1, "R8", "single fetch", 32'(rd_reqs - r0), 1);
        check(mem[12'hC50 >> 2] == 32'hFEED_0005, "R10", "held write completed", mem[12'hC50 >> 2], 32'hFEED_0005);

        idle(4);
        report();
        $finish;
    end
endmodule